// File: doc/BRIEF.md
# SIMD Multiply-Accumulate Pipeline Unit

This block is a 16-bit SIMD multiply-accumulate engine with its own small register file of eight 64-bit registers, its own issue logic and its own hazard scoreboard. One instruction is offered per cycle on a valid/ready issue port. A multiply-accumulate (MAC) takes two source registers and splits each into four 16-bit lanes. It multiplies the lanes pairwise and adds the sum of the four products into a destination register, which also acts as the accumulator. Signed or unsigned interpretation is chosen per instruction.

The other instruction kinds stand in for work that runs on other pipelines. These are a register write with immediate data, a register read that returns the value on a read port, and a no-op. The scoreboard holds the issue port (ready low) while the multiplier is still occupied or while a source operand is a MAC result that is not ready yet. One case is exempt: a MAC that accumulates into the register written by the previous MAC takes the accumulator through an internal forwarding path. Such a MAC waits only for the multiplier.

Top module: `mac_simd_unit`

## Requirements
- R1: After synchronous reset, every register holds zero, `rd_valid` is low and the issue port is ready.
- R2: Opcode 1 (write) stores `in_imm` into register `in_dst`. Opcode 2 (read) returns register `in_srca` on `rd_data`, with `rd_valid` high, in the cycle after it is accepted.
- R3: Opcode 3 (MAC) with `in_sgn`=1 adds the sum of four signed products into `in_dst`, modulo 2^64. Lane i occupies bits 16i+15:16i of both sources, and lane i of source A is multiplied by lane i of source B.
- R4: A MAC with `in_sgn`=0 treats every lane as an unsigned 16-bit value.
- R5: The multiplier is occupied for two cycles. A MAC cannot be accepted at the clock edge right after another MAC's acceptance, even without a data dependency.
- R6: A MAC result has a two-cycle result latency. After a MAC is accepted at edge e, the following cannot be accepted before edge e+3: a read of its destination, a write to its destination, or a MAC naming it as a source.
- R7: A MAC whose destination equals the previous MAC's destination gets the accumulator by forwarding. It can be accepted at edge e+2 and yields the chained sum.
- R8: A no-op, or a read or write of a register with no MAC pending, is accepted without stall while a MAC executes.
- R9: While the port is not ready, the offered instruction is not consumed. Each instruction takes effect exactly once, in issue order.
- R10: `rd_valid` is high only in the cycle following an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this edge when valid |
| in_op | input | 2 | 0 no-op, 1 write, 2 read, 3 MAC |
| in_dst | input | 3 | Destination / accumulator register |
| in_srca | input | 3 | Source A register (also read address) |
| in_srcb | input | 3 | Source B register |
| in_sgn | input | 1 | MAC lane interpretation: 1 signed, 0 unsigned |
| in_imm | input | 64 | Data for the write opcode |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 64 | Read result |

## Verification
`in_ready` is combinational on the offered instruction, so it is due in the same cycle. The bench drives each instruction just after the falling edge and compares ready one nanosecond later against a prediction built from the edge numbers of earlier MAC acceptances. Read data is due one cycle after acceptance and is checked at the next falling edge. A MAC result is first visible to a read accepted three edges after the MAC. The bench therefore checks MAC arithmetic only through later reads, against a reference model that updates architectural state at the acceptance edge.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int DATA_W = 64;
    localparam int LANE_W = 16;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int NREG   = 8;
    localparam int RA_W   = $clog2(NREG);
    localparam int PROD_W = 2 * LANE_W + 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [RA_W-1:0]   ridx_t;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_MAC   = 2'd3
    } op_e;

    // operand capture stage
    typedef struct packed {
        logic  vld;
        ridx_t dst;
        word_t opa;
        word_t opb;
        logic  sgn;
        word_t acc;
    } mul_stage_t;

    // reduction stage, feeds writeback
    typedef struct packed {
        logic  vld;
        ridx_t dst;
        word_t acc;
        word_t sum;
    } sum_stage_t;

    function automatic word_t lane_dot(word_t a, word_t b, logic sgn);
        word_t                    total;
        logic signed [LANE_W:0]   xa;
        logic signed [LANE_W:0]   xb;
        logic signed [PROD_W-1:0] prod;
        total = '0;
        for (int i = 0; i < LANES; i++) begin
            xa    = $signed({sgn & a[i*LANE_W+LANE_W-1], a[i*LANE_W +: LANE_W]});
            xb    = $signed({sgn & b[i*LANE_W+LANE_W-1], b[i*LANE_W +: LANE_W]});
            prod  = xa * xb;
            total = total + {{(DATA_W-PROD_W){prod[PROD_W-1]}}, prod};
        end
        return total;
    endfunction

endpackage

// File: rtl/mac_hazard_track.sv
module mac_hazard_track
    import mac_pkg::*;
#(
    parameter int NUM_REGS = NREG,
    parameter int OCC      = 2,
    parameter int RLAT     = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  req_vld,
    input  op_e   req_op,
    input  ridx_t req_dst,
    input  ridx_t req_srca,
    input  ridx_t req_srcb,
    input  logic  accept,
    output logic  stall
);

    localparam int CW = $clog2(RLAT + 1) + 1;
    localparam int BW = $clog2(OCC) + 1;

    logic [CW-1:0] pend [NUM_REGS];
    logic [BW-1:0] busy;
    logic          mac_go;
    logic          res_haz;
    logic          src_haz;

    assign mac_go = accept && (req_op == OP_MAC);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= '0;
            for (int r = 0; r < NUM_REGS; r++) pend[r] <= '0;
        end else begin
            if (mac_go)          busy <= BW'(OCC - 1);
            else if (busy != '0) busy <= busy - 1'b1;
            for (int r = 0; r < NUM_REGS; r++) begin
                if (mac_go && req_dst == ridx_t'(r)) pend[r] <= CW'(RLAT);
                else if (pend[r] != '0)              pend[r] <= pend[r] - 1'b1;
            end
        end
    end

    always_comb begin
        res_haz = (req_op == OP_MAC) && (busy != '0);
        unique case (req_op)
            OP_MAC:   src_haz = (pend[req_srca] != '0) || (pend[req_srcb] != '0)
                                || (pend[req_dst] > CW'(1));
            OP_READ:  src_haz = (pend[req_srca] != '0);
            OP_WRITE: src_haz = (pend[req_dst] != '0);
            default:  src_haz = 1'b0;
        endcase
        stall = req_vld && (res_haz || src_haz);
    end

endmodule

// File: rtl/mac_regfile.sv
module mac_regfile
    import mac_pkg::*;
#(
    parameter int NUM_REGS = NREG
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we_a,
    input  ridx_t wa_a,
    input  word_t wd_a,
    input  logic  we_b,
    input  ridx_t wa_b,
    input  word_t wd_b,
    input  ridx_t ra0,
    input  ridx_t ra1,
    input  ridx_t ra2,
    output word_t rd0,
    output word_t rd1,
    output word_t rd2
);

    word_t mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NUM_REGS; r++) mem[r] <= '0;
        end else begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (we_a && wa_a == ridx_t'(r))      mem[r] <= wd_a;
                else if (we_b && wa_b == ridx_t'(r)) mem[r] <= wd_b;
            end
        end
    end

    assign rd0 = mem[ra0];
    assign rd1 = mem[ra1];
    assign rd2 = mem[ra2];

endmodule

// File: rtl/mac_dot_stage.sv
module mac_dot_stage
    import mac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mul_stage_t s1,
    output sum_stage_t s2
);

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.vld <= s1.vld;
            s2.dst <= s1.dst;
            s2.acc <= s1.acc;
            s2.sum <= s1.vld ? lane_dot(s1.opa, s1.opb, s1.sgn) : '0;
        end
    end

endmodule

// File: rtl/mac_simd_unit.sv
module mac_simd_unit
    import mac_pkg::*;
#(
    parameter int OCC  = 2,
    parameter int RLAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [RA_W-1:0]   in_dst,
    input  logic [RA_W-1:0]   in_srca,
    input  logic [RA_W-1:0]   in_srcb,
    input  logic              in_sgn,
    input  logic [DATA_W-1:0] in_imm,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    op_e        op;
    logic       stall;
    logic       accept;
    word_t      rf_a, rf_b, rf_d;
    word_t      wb_data;
    word_t      acc_in;
    mul_stage_t s1_q;
    sum_stage_t s2_q;
    logic       rd_vld_q;
    word_t      rd_dat_q;

    assign op       = op_e'(in_op);
    assign accept   = in_valid && !stall;
    assign in_ready = !stall;

    mac_hazard_track #(.NUM_REGS(NREG), .OCC(OCC), .RLAT(RLAT)) u_haz (
        .clk      (clk),
        .rst      (rst),
        .req_vld  (in_valid),
        .req_op   (op),
        .req_dst  (in_dst),
        .req_srca (in_srca),
        .req_srcb (in_srcb),
        .accept   (accept),
        .stall    (stall)
    );

    assign wb_data = s2_q.acc + s2_q.sum;

    mac_regfile #(.NUM_REGS(NREG)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .we_a (s2_q.vld),
        .wa_a (s2_q.dst),
        .wd_a (wb_data),
        .we_b (accept && op == OP_WRITE),
        .wa_b (in_dst),
        .wd_b (in_imm),
        .ra0  (in_srca),
        .ra1  (in_srcb),
        .ra2  (in_dst),
        .rd0  (rf_a),
        .rd1  (rf_b),
        .rd2  (rf_d)
    );

    // accumulator forwarding from the writeback stage
    assign acc_in = (s2_q.vld && s2_q.dst == in_dst) ? wb_data : rf_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.vld <= accept && op == OP_MAC;
            s1_q.dst <= in_dst;
            s1_q.opa <= rf_a;
            s1_q.opb <= rf_b;
            s1_q.sgn <= in_sgn;
            s1_q.acc <= acc_in;
        end
    end

    mac_dot_stage u_dot (
        .clk (clk),
        .rst (rst),
        .s1  (s1_q),
        .s2  (s2_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld_q <= 1'b0;
            rd_dat_q <= '0;
        end else begin
            rd_vld_q <= accept && op == OP_READ;
            if (accept && op == OP_READ) rd_dat_q <= rf_a;
        end
    end

    assign rd_valid = rd_vld_q;
    assign rd_data  = rd_dat_q;

endmodule

// File: rtl/mac_simd_checker.sv
module mac_simd_checker
    import mac_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            in_ready,
    input logic [1:0]      in_op,
    input logic [RA_W-1:0] in_dst,
    input logic [RA_W-1:0] in_srca,
    input logic [RA_W-1:0] in_srcb,
    input logic            rd_valid
);

    logic acc_now;
    logic mac_now;
    logic read_now;

    assign acc_now  = in_valid && in_ready;
    assign mac_now  = acc_now && in_op == 2'd3;
    assign read_now = acc_now && in_op == 2'd2;

    function automatic logic uses_reg(logic [1:0] o, logic [RA_W-1:0] d,
                                      logic [RA_W-1:0] a, logic [RA_W-1:0] b,
                                      logic [RA_W-1:0] r);
        case (o)
            2'd3:    return (a == r) || (b == r);
            2'd2:    return a == r;
            2'd1:    return d == r;
            default: return 1'b0;
        endcase
    endfunction

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !rd_valid); // R1

    AST_MAC_SPACING: assert property (@(posedge clk) disable iff (rst)
        mac_now |=> !mac_now); // R5

    AST_RESULT_WAIT1: assert property (@(posedge clk) disable iff (rst)
        mac_now |=> !(acc_now && uses_reg(in_op, in_dst, in_srca, in_srcb, $past(in_dst)))); // R6

    AST_RESULT_WAIT2: assert property (@(posedge clk) disable iff (rst)
        mac_now |=> ##1 !(acc_now && uses_reg(in_op, in_dst, in_srca, in_srcb, $past(in_dst, 2)))); // R6

    AST_READ_RETURN: assert property (@(posedge clk) disable iff (rst)
        read_now |=> rd_valid); // R2

    AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !read_now |=> !rd_valid); // R10

    AST_NOP_FREE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd0) |-> in_ready); // R8

endmodule

bind mac_simd_unit mac_simd_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_op    (in_op),
    .in_dst   (in_dst),
    .in_srca  (in_srca),
    .in_srcb  (in_srcb),
    .rd_valid (rd_valid)
);

// File: tb/sim_mac_simd_unit.sv
`timescale 1ns/1ps
module sim_mac_simd_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [1:0]  in_op;
    logic [2:0]  in_dst, in_srca, in_srcb;
    logic        in_sgn;
    logic [63:0] in_imm;
    logic        rd_valid;
    logic [63:0] rd_data;

    int ntests = 0;
    int nfail  = 0;
    int ecnt   = 0;

    logic [63:0] mrf [8];
    int          macw [8];
    int          lastmac;
    logic        rd_pend;
    logic [63:0] rd_exp;
    string       rd_req;

    always #2.5 clk = ~clk;
    always @(posedge clk) ecnt <= ecnt + 1;

    mac_simd_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_dst(in_dst), .in_srca(in_srca), .in_srcb(in_srcb),
        .in_sgn(in_sgn), .in_imm(in_imm), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [63:0] ref_dot(logic [63:0] a, logic [63:0] b, logic s);
        longint sum = 0;
        for (int i = 0; i < 4; i++) begin
            if (s) sum += longint'($signed(a[16*i +: 16])) * longint'($signed(b[16*i +: 16]));
            else   sum += longint'(a[16*i +: 16]) * longint'(b[16*i +: 16]);
        end
        return sum;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd_check();
        if (rd_pend) begin
            check(rd_valid === 1'b1, rd_req, "rd_valid after read", {63'd0, rd_valid}, 64'd1);
            check(rd_data === rd_exp, rd_req, "read data", rd_data, rd_exp);
            rd_pend = 1'b0;
        end else begin
            check(rd_valid === 1'b0, "R10", "rd_valid idle", {63'd0, rd_valid}, 64'd0);
        end
    endtask

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic issue(logic [1:0] op, logic [2:0] d, logic [2:0] a, logic [2:0] b,
                         logic s, logic [63:0] imm, string rq);
        int  waited = 0;
        bit  exp_rdy;
        int  e;
        string why;
        in_valid = 1'b1; in_op = op; in_dst = d; in_srca = a; in_srcb = b;
        in_sgn = s; in_imm = imm;
        forever begin
            #1;
            e = ecnt + 1;
            exp_rdy = 1'b1; why = "R8";
            case (op)
                2'd3: begin
                    if (e - lastmac < 2) begin exp_rdy = 0; why = "R5"; end
                    else if (e - macw[a] < 3 || e - macw[b] < 3) begin exp_rdy = 0; why = "R6"; end
                    else if (e - macw[d] < 2) begin exp_rdy = 0; why = "R7"; end
                    else if (e - macw[d] == 2) why = "R7";
                end
                2'd2: if (e - macw[a] < 3) begin exp_rdy = 0; why = "R6"; end
                2'd1: if (e - macw[d] < 3) begin exp_rdy = 0; why = "R6"; end
                default: ;
            endcase
            check(in_ready === exp_rdy, why, "issue ready", {63'd0, in_ready}, {63'd0, exp_rdy});
            if (in_ready) break;
            @(negedge clk);
            rd_check();
            waited++;
            if (waited > 8) begin
                check(1'b0, "R9", "stall never released", 64'd0, 64'd1);
                in_valid = 1'b0;
                return;
            end
        end
        @(posedge clk);
        case (op)
            2'd3: begin
                mrf[d]  = mrf[d] + ref_dot(mrf[a], mrf[b], s);
                macw[d] = e;
                lastmac = e;
            end
            2'd1: mrf[d] = imm;
            2'd2: begin rd_pend = 1'b1; rd_exp = mrf[a]; rd_req = rq; end
            default: ;
        endcase
        @(negedge clk);
        in_valid = 1'b0;
        rd_check();
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_check();
        end
    endtask

    task automatic read_expect(logic [2:0] r, logic [63:0] lit, string rq);
        issue(2'd2, 3'd0, r, 3'd0, 1'b0, 64'd0, rq);
        check(rd_data === lit, rq, "literal result", rd_data, lit);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        ntests++; nfail++;
        $display("FAIL R9 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int r = 0; r < 8; r++) begin mrf[r] = '0; macw[r] = -100; end
        lastmac = -100; rd_pend = 1'b0; rd_exp = '0; rd_req = "R2";
        rst = 1'b1; in_valid = 1'b0; in_op = 2'd0; in_dst = '0; in_srca = '0;
        in_srcb = '0; in_sgn = 1'b0; in_imm = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        in_valid = 1'b1; in_op = 2'd0; #1;
        check(in_ready === 1'b1, "R1", "ready after reset", {63'd0, in_ready}, 64'd1);
        check(rd_valid === 1'b0, "R1", "rd_valid after reset", {63'd0, rd_valid}, 64'd0);
        in_valid = 1'b0;
        @(negedge clk);
        for (int r = 0; r < 8; r++) read_expect(3'(r), 64'd0, "R1");

        // R2: write then read
        issue(2'd1, 3'd1, 0, 0, 0, 64'h0123_4567_89ab_cdef, "R2");
        read_expect(3'd1, 64'h0123_4567_89ab_cdef, "R2");

        // R3: signed extremes, -32768 * -32768 in every lane
        issue(2'd1, 3'd2, 0, 0, 0, 64'h8000_8000_8000_8000, "R3");
        issue(2'd1, 3'd3, 0, 0, 0, 64'h8000_8000_8000_8000, "R3");
        issue(2'd3, 3'd4, 3'd2, 3'd3, 1'b1, 0, "R3");
        idle(3);
        read_expect(3'd4, 64'h0000_0001_0000_0000, "R3");

        // R4: unsigned versus signed on all-ones lanes
        issue(2'd1, 3'd6, 0, 0, 0, 64'hffff_ffff_ffff_ffff, "R4");
        issue(2'd1, 3'd7, 0, 0, 0, 64'hffff_ffff_ffff_ffff, "R4");
        issue(2'd3, 3'd5, 3'd6, 3'd6, 1'b0, 0, "R4");
        issue(2'd3, 3'd7, 3'd6, 3'd6, 1'b1, 0, "R3");
        idle(3);
        read_expect(3'd5, 64'h0000_0003_fff8_0004, "R4");
        read_expect(3'd7, 64'h0000_0000_0000_0003, "R3");

        // R5 + R7: accumulate chain into r4 with back-to-back issue
        issue(2'd3, 3'd4, 3'd2, 3'd3, 1'b1, 0, "R7");
        issue(2'd3, 3'd4, 3'd2, 3'd3, 1'b1, 0, "R7");
        issue(2'd3, 3'd4, 3'd2, 3'd3, 1'b1, 0, "R7");
        idle(3);
        read_expect(3'd4, 64'h0000_0004_0000_0000, "R7");

        // R6: read right behind a MAC stalls two cycles
        issue(2'd3, 3'd0, 3'd6, 3'd6, 1'b0, 0, "R6");
        read_expect(3'd0, 64'h0000_0003_fff8_0004, "R6");

        // R8: unrelated traffic flows while a MAC runs
        issue(2'd3, 3'd5, 3'd6, 3'd6, 1'b0, 0, "R8");
        issue(2'd1, 3'd1, 0, 0, 0, 64'h5555_aaaa_1234_8765, "R8");
        issue(2'd2, 3'd0, 3'd1, 0, 0, 0, "R8");
        issue(2'd0, 0, 0, 0, 0, 0, "R8");
        idle(3);

        // R9: random mix with hazards
        for (int n = 0; n < 3000; n++) begin
            int k = $urandom_range(0, 99);
            logic [63:0] im;
            case ($urandom_range(0, 3))
                0: im = 64'h8000_7fff_ffff_0001;
                1: im = {$urandom, $urandom};
                2: im = {4{16'($urandom)}};
                default: im = {$urandom, $urandom} & 64'h8fff_8fff_8fff_8fff;
            endcase
            if (k < 40)      issue(2'd3, 3'($urandom_range(0,7)), 3'($urandom_range(0,7)),
                                   3'($urandom_range(0,7)), 1'($urandom), 0, "R9");
            else if (k < 65) issue(2'd2, 0, 3'($urandom_range(0,7)), 0, 0, 0, "R9");
            else if (k < 88) issue(2'd1, 3'($urandom_range(0,7)), 0, 0, 0, im, "R9");
            else if (k < 95) issue(2'd0, 0, 0, 0, 0, 0, "R8");
            else             idle($urandom_range(1, 3));
        end
        idle(3);
        for (int r = 0; r < 8; r++) issue(2'd2, 0, 3'(r), 0, 0, 0, "R9");
        idle(2);

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule